// File: doc/BRIEF.md
# Descriptor-Ring DMA Channel Sequencer

This block is one DMA channel that walks a ring of 16-byte command descriptors held in memory. It reads each descriptor through a simple memory port and carries out the command. An output descriptor reads words from memory and hands them to a streaming output port. An input descriptor takes words from a streaming input port and writes them to memory. A no-op descriptor only redirects the walk. A stop descriptor ends it.

After every transfer descriptor the channel writes a status word back into the descriptor. It can then raise a one-cycle interrupt. It picks the next descriptor either sequentially or from the descriptor's dependency address. That choice can depend on software-owned status bits, which is how software asks for a clean halt. Software builds a ring of transfer descriptors, each coded "branch if set" towards a stop descriptor, and closes the ring with a no-op that branches back to the start. To halt, software sets status bit S0. The channel finishes the descriptor in progress, takes the branch, records that it did so in the written-back status, and stops. On the capture direction it also raises S7 to show that everything received has reached memory.

Software reaches four 32-bit registers through a small register port. Control writes carry a bit mask in the upper half and new values in the lower half, so that one write can change any subset of bits without a read-modify-write.

Top module: `ring_dma_seq`

## Requirements
- R1: After reset the status reads 0, the command pointer reads 0, and `irq`, `mem_req`, `out_valid` and `in_ready` are all low.
- R2: Registers by `reg_addr`: 0 is control (write) and status (read), 1 is status (read only), 2 is branch select, 3 is command pointer. Status holds RUN at bit 15, PAUSE at bit 14, ACTIVE at bit 10 and S7..S0 at bits 7:0. A control write changes bits 15, 14 and 7:0, each only where the mask in bits 31:16 is set, taking its value from bits 15:0. Bits whose mask is clear keep their value.
- R3: A control write that takes RUN from 0 to 1 sets ACTIVE and starts fetching at the command pointer. A descriptor at address P occupies four words. Word P holds the command in [31:16] and the byte count in [15:0]. Word P+4 holds the data address, word P+8 holds the dependency address, and word P+12 receives the write-back.
- R4: The command field encodes the opcode in [15:12] (0 output, 2 input, 6 no-op, 7 stop, any other value a no-op). It encodes the interrupt option in [5:4] (3 = always, anything else = never) and the branch option in [3:2] (1 = if condition, 3 = always, anything else = never).
- R5: An output descriptor reads its byte count as 32-bit words from ascending addresses starting at the data address. It presents each word on `out_data` with `out_valid` and holds the word until `out_ready`.
- R6: An input descriptor accepts words from the input stream only through `in_valid`/`in_ready` and writes them to ascending addresses. `in_ready` is low whenever no input descriptor is waiting for data, so pending input is held back rather than lost.
- R7: After the last word of a transfer descriptor, or straight away for a zero count, the channel writes word P+12. That word carries status in [31:16] (bit 15 = done, bit 8 = branch taken, bits 7:0 = S7..S0 at that moment) and the residual byte count in [15:0], which is 0 on normal completion.
- R8: Branch select holds a mask in [23:16] and values in [7:0]. The condition is true when any masked S bit equals its value bit. The branch is evaluated only at the end of a descriptor. If taken, the next descriptor is at the dependency address; otherwise it is at P+16.
- R9: A no-op descriptor coded branch-always reloads the command pointer from its dependency address and writes nothing back.
- R10: A stop descriptor clears ACTIVE, leaves RUN set and leaves the command pointer on the stop descriptor. It sets S7 when the last transfer descriptor executed was an input descriptor.
- R11: `irq` is a single-cycle pulse that follows the write-back of each descriptor whose interrupt option is "always".
- R12: Writes to the command pointer are ignored while ACTIVE is set and take effect while it is clear.
- R13: Clearing RUN turns the channel off at once: ACTIVE, `mem_req` and `out_valid` drop.
- R14: While PAUSE is set, the channel waits before fetching the next descriptor and issues no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory request completed |
| out_valid | output | 1 | Output stream word valid |
| out_data | output | 32 | Output stream word |
| out_ready | input | 1 | Output stream consumer ready |
| in_valid | input | 1 | Input stream word valid |
| in_data | input | 32 | Input stream word |
| in_ready | output | 1 | Channel accepts an input word |
| irq | output | 1 | Per-descriptor interrupt pulse |

## Verification
The assertions assume four things about the environment:
- the memory keeps `mem_rdata` meaningful only in the acknowledge cycle;
- the memory never acknowledges a request that is not pending;
- software writes the command pointer only while the channel is idle;
- byte counts are multiples of four.

The bench's memory model acknowledges each request one cycle after it appears and never acknowledges in two back-to-back cycles. The stimulus places every descriptor at a 16-byte aligned address with a count of 0, 8 or 12 bytes. The stop request (S0) is raised while the channel is stalled in the middle of an input descriptor, so the branch decision at that descriptor's end is unambiguous.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;
  localparam int ADDR_W     = 32;
  localparam int DATA_W     = 32;
  localparam int CNT_W      = 16;
  localparam int SBIT_W     = 8;
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int DESC_BYTES = 4 * WORD_BYTES;

  // command opcodes, field [15:12] of the command half-word
  localparam logic [3:0] OP_OUT  = 4'h0;
  localparam logic [3:0] OP_IN   = 4'h2;
  localparam logic [3:0] OP_NOP  = 4'h6;
  localparam logic [3:0] OP_STOP = 4'h7;

  localparam logic [1:0] IRQ_ALWAYS = 2'b11;
  localparam logic [1:0] BR_IFSET   = 2'b01;
  localparam logic [1:0] BR_ALWAYS  = 2'b11;

  // register indices
  localparam logic [1:0] RIDX_CTRL  = 2'd0;
  localparam logic [1:0] RIDX_STAT  = 2'd1;
  localparam logic [1:0] RIDX_BRSEL = 2'd2;
  localparam logic [1:0] RIDX_CPTR  = 2'd3;

  // status bit positions
  localparam int BIT_RUN    = 15;
  localparam int BIT_PAUSE  = 14;
  localparam int BIT_ACTIVE = 10;
  localparam int BIT_FLUSH  = 7;

  typedef enum logic [3:0] {
    ST_IDLE, ST_NEXT, ST_F0, ST_F1, ST_F2,
    ST_RD, ST_OUT, ST_IN, ST_WR, ST_WB, ST_BR
  } eng_state_t;
endpackage

// File: rtl/ring_dma_brcond.sv
module ring_dma_brcond
  import ring_dma_pkg::*;
(
  input  logic [SBIT_W-1:0] sbits_i,
  input  logic [SBIT_W-1:0] sel_mask_i,
  input  logic [SBIT_W-1:0] sel_val_i,
  input  logic [1:0]        br_mode_i,
  output logic              take_o
);
  logic [SBIT_W-1:0] hit;

  // per status bit: selected and equal to the wanted value
  for (genvar i = 0; i < SBIT_W; i++) begin : g_bit
    assign hit[i] = sel_mask_i[i] & ~(sbits_i[i] ^ sel_val_i[i]);
  end

  assign take_o = (br_mode_i == BR_ALWAYS) |
                  ((br_mode_i == BR_IFSET) & (|hit));
endmodule

// File: rtl/ring_dma_regs.sv
module ring_dma_regs
  import ring_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              active_i,
  input  logic              set_s7_i,
  input  logic              ptr_upd_i,
  input  logic [ADDR_W-1:0] ptr_val_i,
  output logic              run_o,
  output logic              pause_o,
  output logic              start_o,
  output logic [SBIT_W-1:0] sbits_o,
  output logic [SBIT_W-1:0] sel_mask_o,
  output logic [SBIT_W-1:0] sel_val_o,
  output logic [ADDR_W-1:0] cmdptr_o
);
  logic              run_q, run_d, pause_q, pause_d;
  logic [SBIT_W-1:0] s_q, s_d, selm_q, selm_d, selv_q, selv_d;
  logic [ADDR_W-1:0] cptr_q, cptr_d;
  logic              ctrl_wr;
  logic [15:0]       wmask, wval, stat;

  assign ctrl_wr = reg_we && (reg_addr == RIDX_CTRL);
  assign wmask   = reg_wdata[31:16];
  assign wval    = reg_wdata[15:0];

  always_comb begin
    run_d   = run_q;
    pause_d = pause_q;
    s_d     = s_q;
    selm_d  = selm_q;
    selv_d  = selv_q;
    cptr_d  = cptr_q;
    if (ctrl_wr) begin
      if (wmask[BIT_RUN])   run_d   = wval[BIT_RUN];
      if (wmask[BIT_PAUSE]) pause_d = wval[BIT_PAUSE];
      s_d = (s_q & ~wmask[SBIT_W-1:0]) | (wval[SBIT_W-1:0] & wmask[SBIT_W-1:0]);
    end
    if (set_s7_i) s_d[BIT_FLUSH] = 1'b1;
    if (reg_we && (reg_addr == RIDX_BRSEL)) begin
      selm_d = reg_wdata[16 +: SBIT_W];
      selv_d = reg_wdata[0 +: SBIT_W];
    end
    if (ptr_upd_i)
      cptr_d = ptr_val_i;
    else if (reg_we && (reg_addr == RIDX_CPTR) && !active_i)
      cptr_d = reg_wdata[ADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      pause_q <= 1'b0;
      s_q     <= '0;
      selm_q  <= '0;
      selv_q  <= '0;
      cptr_q  <= '0;
    end else begin
      run_q   <= run_d;
      pause_q <= pause_d;
      s_q     <= s_d;
      selm_q  <= selm_d;
      selv_q  <= selv_d;
      cptr_q  <= cptr_d;
    end
  end

  assign start_o = ctrl_wr && wmask[BIT_RUN] && wval[BIT_RUN] && !run_q;

  always_comb begin
    stat = '0;
    stat[BIT_RUN]      = run_q;
    stat[BIT_PAUSE]    = pause_q;
    stat[BIT_ACTIVE]   = active_i;
    stat[SBIT_W-1:0]   = s_q;
  end

  always_comb begin
    unique case (reg_addr)
      RIDX_CTRL, RIDX_STAT: reg_rdata = {16'h0, stat};
      RIDX_BRSEL:           reg_rdata = {8'h0, selm_q, 8'h0, selv_q};
      default:              reg_rdata = cptr_q;
    endcase
  end

  assign run_o      = run_q;
  assign pause_o    = pause_q;
  assign sbits_o    = s_q;
  assign sel_mask_o = selm_q;
  assign sel_val_o  = selv_q;
  assign cmdptr_o   = cptr_q;

  // R12: a busy channel owns the pointer; software writes leave it alone
  p_cptr_locked_r12: assert property (@(posedge clk) disable iff (!rst_n)
    active_i && !ptr_upd_i |=> $stable(cptr_q));

  // R2: S0 moves only under a control write whose mask selects it
  p_s0_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl_wr && wmask[0]) |=> $stable(s_q[0]));
endmodule

// File: rtl/ring_dma_engine.sv
module ring_dma_engine
  import ring_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              pause_i,
  input  logic              start_i,
  input  logic [SBIT_W-1:0] sbits_i,
  input  logic [SBIT_W-1:0] sel_mask_i,
  input  logic [SBIT_W-1:0] sel_val_i,
  input  logic [ADDR_W-1:0] cmdptr_i,
  output logic              active_o,
  output logic              set_s7_o,
  output logic              ptr_upd_o,
  output logic [ADDR_W-1:0] ptr_val_o,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              irq
);
  eng_state_t        state_q, state_d;
  logic [3:0]        op_q, op_d;
  logic [1:0]        irqm_q, irqm_d, brm_q, brm_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] daddr_q, daddr_d, dep_q, dep_d;
  logic [DATA_W-1:0] dbuf_q, dbuf_d;
  logic              last_in_q, last_in_d, irq_q, irq_d;
  logic              take, last_word;
  logic [15:0]       xstat;

  ring_dma_brcond u_brcond (
    .sbits_i    (sbits_i),
    .sel_mask_i (sel_mask_i),
    .sel_val_i  (sel_val_i),
    .br_mode_i  (brm_q),
    .take_o     (take)
  );

  assign last_word = (cnt_q <= CNT_W'(WORD_BYTES));
  assign xstat     = {1'b1, 6'b0, take, sbits_i};

  always_comb begin
    state_d   = state_q;
    op_d      = op_q;
    irqm_d    = irqm_q;
    brm_d     = brm_q;
    cnt_d     = cnt_q;
    daddr_d   = daddr_q;
    dep_d     = dep_q;
    dbuf_d    = dbuf_q;
    last_in_d = last_in_q;
    irq_d     = 1'b0;
    ptr_upd_o = 1'b0;
    ptr_val_o = take ? dep_q : cmdptr_i + ADDR_W'(DESC_BYTES);
    set_s7_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: ;
      ST_NEXT: if (!pause_i) state_d = ST_F0;
      ST_F0: if (mem_ack) begin
        op_d   = mem_rdata[31:28];
        irqm_d = mem_rdata[21:20];
        brm_d  = mem_rdata[19:18];
        cnt_d  = mem_rdata[CNT_W-1:0];
        if (mem_rdata[31:28] == OP_STOP) begin
          set_s7_o = last_in_q;
          state_d  = ST_IDLE;
        end else begin
          state_d = ST_F1;
        end
      end
      ST_F1: if (mem_ack) begin
        daddr_d = mem_rdata;
        state_d = ST_F2;
      end
      ST_F2: if (mem_ack) begin
        dep_d = mem_rdata;
        if (op_q == OP_OUT) begin
          last_in_d = 1'b0;
          state_d   = (cnt_q == '0) ? ST_WB : ST_RD;
        end else if (op_q == OP_IN) begin
          last_in_d = 1'b1;
          state_d   = (cnt_q == '0) ? ST_WB : ST_IN;
        end else begin
          state_d = ST_BR;
        end
      end
      ST_RD: if (mem_ack) begin
        dbuf_d  = mem_rdata;
        state_d = ST_OUT;
      end
      ST_OUT: if (out_ready) begin
        cnt_d   = last_word ? '0 : cnt_q - CNT_W'(WORD_BYTES);
        daddr_d = daddr_q + ADDR_W'(WORD_BYTES);
        state_d = last_word ? ST_WB : ST_RD;
      end
      ST_IN: if (in_valid) begin
        dbuf_d  = in_data;
        state_d = ST_WR;
      end
      ST_WR: if (mem_ack) begin
        cnt_d   = last_word ? '0 : cnt_q - CNT_W'(WORD_BYTES);
        daddr_d = daddr_q + ADDR_W'(WORD_BYTES);
        state_d = last_word ? ST_WB : ST_IN;
      end
      ST_WB: if (mem_ack) begin
        irq_d     = (irqm_q == IRQ_ALWAYS);
        ptr_upd_o = 1'b1;
        state_d   = ST_NEXT;
      end
      ST_BR: begin
        ptr_upd_o = 1'b1;
        state_d   = ST_NEXT;
      end
      default: state_d = ST_IDLE;
    endcase
    if (start_i) begin
      state_d   = ST_NEXT;
      last_in_d = 1'b0;
      ptr_upd_o = 1'b0;
      set_s7_o  = 1'b0;
      irq_d     = 1'b0;
    end else if (!run_i && state_q != ST_IDLE) begin
      state_d   = ST_IDLE;
      ptr_upd_o = 1'b0;
      set_s7_o  = 1'b0;
      irq_d     = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      op_q      <= '0;
      irqm_q    <= '0;
      brm_q     <= '0;
      cnt_q     <= '0;
      daddr_q   <= '0;
      dep_q     <= '0;
      dbuf_q    <= '0;
      last_in_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      op_q      <= op_d;
      irqm_q    <= irqm_d;
      brm_q     <= brm_d;
      cnt_q     <= cnt_d;
      daddr_q   <= daddr_d;
      dep_q     <= dep_d;
      dbuf_q    <= dbuf_d;
      last_in_q <= last_in_d;
      irq_q     <= irq_d;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_F0:   mem_addr = cmdptr_i;
      ST_F1:   mem_addr = cmdptr_i + ADDR_W'(WORD_BYTES);
      ST_F2:   mem_addr = cmdptr_i + ADDR_W'(2 * WORD_BYTES);
      ST_WB:   mem_addr = cmdptr_i + ADDR_W'(3 * WORD_BYTES);
      default: mem_addr = daddr_q;
    endcase
  end

  assign mem_req   = (state_q == ST_F0) || (state_q == ST_F1) || (state_q == ST_F2) ||
                     (state_q == ST_RD) || (state_q == ST_WR) || (state_q == ST_WB);
  assign mem_we    = (state_q == ST_WR) || (state_q == ST_WB);
  assign mem_wdata = (state_q == ST_WB) ? {xstat, cnt_q} : dbuf_q;
  assign out_valid = (state_q == ST_OUT);
  assign out_data  = dbuf_q;
  assign in_ready  = (state_q == ST_IN);
  assign active_o  = (state_q != ST_IDLE);
  assign irq       = irq_q;

  // R11: the interrupt never lasts two cycles
  p_irq_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R5: an offered output word stays put until taken
  p_out_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && run_i |=> out_valid && $stable(out_data));

  // R6: input back-pressure persists until a word arrives
  p_in_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && !in_valid && run_i |=> in_ready);

  // R3: a pending memory request is neither withdrawn nor moved
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && run_i |=> mem_req && $stable(mem_addr));

  // R10: reaching a stop descriptor leaves the channel inactive
  p_stop_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    set_s7_o |=> !active_o);
endmodule

// File: rtl/ring_dma_seq.sv
module ring_dma_seq
  import ring_dma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack,
  output logic        out_valid,
  output logic [31:0] out_data,
  input  logic        out_ready,
  input  logic        in_valid,
  input  logic [31:0] in_data,
  output logic        in_ready,
  output logic        irq
);
  logic              run, pause, start, active, set_s7, ptr_upd;
  logic [SBIT_W-1:0] sbits, sel_mask, sel_val;
  logic [ADDR_W-1:0] cmdptr, ptr_val;

  ring_dma_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .active_i   (active),
    .set_s7_i   (set_s7),
    .ptr_upd_i  (ptr_upd),
    .ptr_val_i  (ptr_val),
    .run_o      (run),
    .pause_o    (pause),
    .start_o    (start),
    .sbits_o    (sbits),
    .sel_mask_o (sel_mask),
    .sel_val_o  (sel_val),
    .cmdptr_o   (cmdptr)
  );

  ring_dma_engine u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run),
    .pause_i    (pause),
    .start_i    (start),
    .sbits_i    (sbits),
    .sel_mask_i (sel_mask),
    .sel_val_i  (sel_val),
    .cmdptr_i   (cmdptr),
    .active_o   (active),
    .set_s7_o   (set_s7),
    .ptr_upd_o  (ptr_upd),
    .ptr_val_o  (ptr_val),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .mem_ack    (mem_ack),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_ready  (out_ready),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_ready   (in_ready),
    .irq        (irq)
  );
endmodule

// File: tb/ring_dma_seq_bench.sv
`timescale 1ns/1ps
module ring_dma_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        out_valid, out_ready, in_valid, in_ready, irq;
  logic [31:0] out_data, in_data;

  logic        ld_en = 1'b0;
  logic [31:0] ld_addr = 32'h0, ld_data = 32'h0;
  logic [31:0] mem [0:1023];
  logic        rdy_en = 1'b0;
  logic [1:0]  rdy_cnt;
  int          in_idx;
  int          in_lim = 0;

  int checks = 0, errors = 0;
  int mon_checks = 0, mon_errors = 0, irq_cnt = 0, cyc = 0;
  logic [31:0] exp_out[$];
  logic [63:0] exp_wr[$];

  always #2 clk = ~clk;

  ring_dma_seq u_ring_dma_seq (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .irq(irq)
  );

  // memory model: one-cycle acknowledge, no back-to-back acknowledges
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= 32'h0;
      rdy_cnt   <= 2'd0;
      in_idx    <= 0;
    end else begin
      mem_ack   <= mem_req & ~mem_ack;
      mem_rdata <= mem[mem_addr[11:2]];
      if (mem_req && mem_we && mem_ack) mem[mem_addr[11:2]] <= mem_wdata;
      if (ld_en) mem[ld_addr[11:2]] <= ld_data;
      rdy_cnt <= rdy_cnt + 2'd1;
      if (in_valid && in_ready) in_idx <= in_idx + 1;
    end
  end

  assign out_ready = rdy_en && (rdy_cnt != 2'd3);
  assign in_valid  = (in_idx < in_lim);
  assign in_data   = 32'h1000_0000 + 32'(in_idx);

  // scoreboard monitor, sampled on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq) irq_cnt++;
      if (out_valid && out_ready) begin
        mon_checks++;
        if (exp_out.size() == 0) begin
          mon_errors++;
          $display("FAIL R5 unexpected output word actual=%h expected=none", out_data);
        end else begin
          logic [31:0] e;
          e = exp_out.pop_front();
          if (out_data !== e) begin
            mon_errors++;
            $display("FAIL R5 output word actual=%h expected=%h", out_data, e);
          end
        end
      end
      if (mem_req && mem_we && mem_ack) begin
        mon_checks++;
        if (exp_wr.size() == 0) begin
          mon_errors++;
          $display("FAIL R6 R7 unexpected write actual=%h:%h expected=none", mem_addr, mem_wdata);
        end else begin
          logic [63:0] e;
          e = exp_wr.pop_front();
          if ({mem_addr, mem_wdata} !== e) begin
            mon_errors++;
            $display("FAIL R6 R7 memory write actual=%h:%h expected=%h:%h",
                     mem_addr, mem_wdata, e[63:32], e[31:0]);
          end
        end
      end
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks + mon_checks, errors + mon_errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000 cycles", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic desc(input logic [31:0] a, input logic [31:0] w0,
                      input logic [31:0] w1, input logic [31:0] w2);
    poke(a, w0); poke(a + 4, w1); poke(a + 8, w2); poke(a + 12, 32'h0);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic expect_out(input logic [31:0] w);
    exp_out.push_back(w);
  endtask

  task automatic expect_wr(input logic [31:0] a, input logic [31:0] d);
    exp_wr.push_back({a, d});
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      reg_read(2'd1, s);
      if (!s[10]) return;
    end
    check("R10 channel never went idle", s & 32'h400, 32'h0);
  endtask

  initial begin
    logic [31:0] r;
    int req_seen;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    reg_read(2'd1, r);  check("R1 status", r, 32'h0);
    reg_read(2'd3, r);  check("R1 cmdptr", r, 32'h0);
    check("R1 outputs", {28'h0, irq, mem_req, out_valid, in_ready}, 32'h0);

    // R2: masked control writes
    reg_write(2'd0, 32'h0002_0002);
    reg_read(2'd0, r);  check("R2 set S1", r, 32'h0000_0002);
    reg_write(2'd0, 32'h0003_0001);
    reg_read(2'd1, r);  check("R2 set S0 clear S1", r, 32'h0000_0001);
    reg_write(2'd0, 32'h0000_00FE);
    reg_read(2'd1, r);  check("R2 empty mask ignored", r, 32'h0000_0001);
    reg_write(2'd0, 32'h0001_0000);

    // R12: pointer loads while idle
    reg_write(2'd3, 32'h0000_0200);
    reg_read(2'd3, r);  check("R12 idle pointer write", r, 32'h0000_0200);

    // output descriptor then stop (R3 R4 R5 R7 R11)
    poke(32'h600, 32'hA1A1_0001); poke(32'h604, 32'hB2B2_0002); poke(32'h608, 32'hC3C3_0003);
    desc(32'h200, 32'h0030_000C, 32'h0000_0600, 32'h0);
    desc(32'h210, 32'h7000_0000, 32'h0, 32'h0);
    expect_out(32'hA1A1_0001); expect_out(32'hB2B2_0002); expect_out(32'hC3C3_0003);
    expect_wr(32'h20C, 32'h8000_0000);
    rdy_en = 1'b1;
    reg_write(2'd0, 32'h8000_8000);
    wait_idle();
    check("R5 output queue drained", 32'(exp_out.size()), 32'h0);
    check("R7 write-back done", 32'(exp_wr.size()), 32'h0);
    check("R11 one interrupt", 32'(irq_cnt), 32'd1);
    reg_read(2'd1, r);  check("R10 stop keeps RUN, no S7 after output", r, 32'h0000_8000);
    reg_read(2'd3, r);  check("R10 pointer on stop descriptor", r, 32'h0000_0210);
    reg_write(2'd0, 32'hC001_0000);

    // input ring with graceful stop (R6 R7 R8 R9 R10)
    desc(32'h100, 32'h2034_0008, 32'h0000_0400, 32'h0000_0130);
    desc(32'h110, 32'h2034_0008, 32'h0000_0408, 32'h0000_0130);
    desc(32'h120, 32'h600C_0000, 32'h0, 32'h0000_0100);
    desc(32'h130, 32'h7000_0000, 32'h0, 32'h0);
    reg_write(2'd2, 32'h0001_0001);
    reg_read(2'd2, r);  check("R8 branch select readback", r, 32'h0001_0001);
    reg_write(2'd3, 32'h0000_0100);
    expect_wr(32'h400, 32'h1000_0000); expect_wr(32'h404, 32'h1000_0001);
    expect_wr(32'h10C, 32'h8000_0000);
    expect_wr(32'h408, 32'h1000_0002); expect_wr(32'h40C, 32'h1000_0003);
    expect_wr(32'h11C, 32'h8000_0000);
    expect_wr(32'h400, 32'h1000_0004); expect_wr(32'h404, 32'h1000_0005);
    expect_wr(32'h10C, 32'h8101_0000);
    in_lim = 5;
    reg_write(2'd0, 32'h8000_8000);
    while (in_idx < 5) @(negedge clk);
    repeat (10) @(negedge clk);
    check("R9 ring reopened at first descriptor", 32'(exp_wr.size()), 32'd2);
    check("R6 waiting for input", {31'h0, in_ready}, 32'h1);
    reg_write(2'd3, 32'h0000_0300);
    reg_read(2'd3, r);  check("R12 busy pointer write ignored", r, 32'h0000_0100);
    reg_write(2'd0, 32'h0001_0001);
    in_lim = 7;
    wait_idle();
    repeat (20) @(negedge clk);
    check("R8 branch taken write-back", 32'(exp_wr.size()), 32'h0);
    check("R6 no input taken after stop", 32'(in_idx), 32'd6);
    check("R6 in_ready low when idle", {31'h0, in_ready}, 32'h0);
    check("R11 three more interrupts", 32'(irq_cnt), 32'd4);
    reg_read(2'd1, r);  check("R10 S7 after input stop", r, 32'h0000_8081);
    reg_read(2'd3, r);  check("R8 pointer at stop target", r, 32'h0000_0130);
    reg_write(2'd0, 32'hC001_0000);

    // pause then abort (R14 R13)
    rdy_en = 1'b0;
    reg_write(2'd3, 32'h0000_0200);
    reg_write(2'd0, 32'hC000_C000);
    req_seen = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (mem_req) req_seen++;
    end
    check("R14 no fetch while paused", 32'(req_seen), 32'h0);
    reg_read(2'd1, r);  check("R14 paused but active", r, 32'h0000_C480);
    reg_write(2'd0, 32'h4000_0000);
    repeat (20) @(negedge clk);
    check("R14 resumes after pause", {31'h0, out_valid}, 32'h1);
    check("R5 first word offered", out_data, 32'hA1A1_0001);
    reg_write(2'd0, 32'h8000_0000);
    repeat (2) @(negedge clk);
    check("R13 outputs off", {30'h0, out_valid, mem_req}, 32'h0);
    reg_read(2'd1, r);  check("R13 inactive", r & 32'h0000_8400, 32'h0);

    summary();
    $finish;
  end
endmodule